// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers event notifications from a network controller's transmit and receive engines and holds them in a status register. It combines that register with a mask register and a global enable register, and from the result it drives a single level-sensitive interrupt line to the host. Twelve event bits are implemented. Every other bit position is reserved. Engines raise events through a per-bit post vector and withdraw them through a per-bit clear vector. A separate request input raises the software-interrupt event.

The host reaches the registers through a simple 32-bit port with a 2-bit register select. Reading the status register returns its contents and empties it in the same access. Writing the status register is illegal: the access is refused and an error pulse is raised. A pending flag drives the interrupt line. The line can assert only while the enable register is nonzero, and it falls as soon as no unmasked status bit remains. The masked condition is re-evaluated on every clock, so a mask write takes effect at once.

Top module: `irq_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the status, mask and enable registers and the pending flag. After reset `irqOut` and `errOut` are 0, and reads of every register return 0.
- R2: Register select 0 is status, 1 is mask, 2 is enable and 3 reads as zero. A read of status returns the current value on `regRdData` in the same cycle and leaves the register at zero after that clock edge.
- R3: A write to register select 0 leaves the status unchanged and makes `errOut` high for the cycle after the write.
- R4: Each asserted bit of `postVec` within the implemented positions sets the matching status bit. The positions are: bit 0 transmit ok, 1 transmit descriptor, 2 transmit error, 3 transmit idle, 4 receive ok, 5 receive descriptor, 6 receive error, 7 receive idle, 8 receive overrun, 9 software interrupt, 10 transmit reset done, 11 receive reset done.
- R5: Each asserted bit of `clearVec` clears the matching status bit. If a post and a clear hit the same bit in one cycle, the bit ends up set.
- R6: A post in the same cycle as a status read is not lost. The next status read returns it.
- R7: Post or clear bits at reserved positions 12 to 31 never change the status. Any such bit makes `errOut` high for the following cycle.
- R8: `swReq` high for a cycle sets status bit 9.
- R9: `irqOut` goes high after the clock edge at which the status AND mask becomes nonzero while the enable register is nonzero.
- R10: `irqOut` falls after the clock edge at which the status AND mask becomes zero. This can happen through a clear, a status read or a mask write.
- R11: While the enable register is zero, `irqOut` cannot rise. Once `irqOut` is high, writing zero to the enable register does not drop it.
- R12: A mask write is re-evaluated at the same edge that stores it. It raises or lowers `irqOut` from the new mask against the current status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select (0 status, 1 mask, 2 enable) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle of `regRdEn`, zero otherwise |
| postVec | input | 32 | Per-bit event post |
| clearVec | input | 32 | Per-bit event clear |
| swReq | input | 1 | Software-interrupt request |
| irqOut | output | 1 | Level interrupt line to the host |
| errOut | output | 1 | Pulse on an illegal status write or a reserved-bit post or clear |

## Verification
The hardest situations to reach are those where two status sources meet at one clock edge. One is a post landing in the same cycle as a status read. The other is a post and a clear on the same bit, combined with a mask or enable write that changes whether the line should be up. Directed sequences set up each collision explicitly, with the interrupt already pending or not. A long pseudo-random phase then drives posts, clears, reads and mask and enable writes together. A behavioural model compares `irqOut`, `errOut` and every read against expected values on each cycle.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int ADDR_W    = 2;
  localparam int IMPL_BITS = 12;

  localparam logic [ADDR_W-1:0] SEL_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_ENABLE = 2'd2;

  // event bit positions
  localparam int EV_TX_OK    = 0;
  localparam int EV_TX_DESC  = 1;
  localparam int EV_TX_ERR   = 2;
  localparam int EV_TX_IDLE  = 3;
  localparam int EV_RX_OK    = 4;
  localparam int EV_RX_DESC  = 5;
  localparam int EV_RX_ERR   = 6;
  localparam int EV_RX_IDLE  = 7;
  localparam int EV_RX_OVER  = 8;
  localparam int EV_SOFT     = 9;
  localparam int EV_TX_RDONE = 10;
  localparam int EV_RX_RDONE = 11;

  typedef struct packed {
    logic statusRd;
    logic maskWr;
    logic enableWr;
  } reg_strobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] postVec,
  input  logic [DATA_W-1:0] clearVec,
  input  logic              swReq,
  output reg_strobe_t       strb,
  output logic [DATA_W-1:0] postEff,
  output logic [DATA_W-1:0] clearEff,
  output logic              errOut
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    {{(DATA_W-IMPL_BITS){1'b0}}, {IMPL_BITS{1'b1}}};
  localparam logic [DATA_W-1:0] SOFT_ONE =
    {{(DATA_W-1){1'b0}}, 1'b1} << EV_SOFT;

  logic illegalWr;
  logic rsvdHit;
  logic errQ;

  always_comb begin
    strb.statusRd = regRdEn && (regAddr == SEL_STATUS);
    strb.maskWr   = regWrEn && (regAddr == SEL_MASK);
    strb.enableWr = regWrEn && (regAddr == SEL_ENABLE);
    illegalWr     = regWrEn && (regAddr == SEL_STATUS);
    rsvdHit       = |((postVec | clearVec) & ~IMPL_MASK);
    postEff       = (postVec & IMPL_MASK) | (swReq ? SOFT_ONE : '0);
    clearEff      = clearVec & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) errQ <= 1'b0;
    else     errQ <= illegalWr || rsvdHit;
  end

  assign errOut = errQ;
endmodule

// File: rtl/irq_status_path.sv
module irq_status_path
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_strobe_t       strb,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] postEff,
  input  logic [DATA_W-1:0] clearEff,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] enableQ,
  output logic              irqOut
);
  logic [DATA_W-1:0] statusNext;
  logic [DATA_W-1:0] maskNext;
  logic [DATA_W-1:0] enableNext;
  logic              pendQ;
  logic              pendNext;
  logic              anyNext;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < IMPL_BITS) begin : g_impl
      // post wins over clear and over the read-clear
      assign statusNext[b] = postEff[b] |
                             (statusQ[b] & ~clearEff[b] & ~strb.statusRd);
    end else begin : g_rsvd
      assign statusNext[b] = 1'b0;
    end
  end

  always_comb begin
    maskNext   = strb.maskWr   ? regWrData : maskQ;
    enableNext = strb.enableWr ? regWrData : enableQ;
    anyNext    = |(statusNext & maskNext);
    pendNext   = pendQ ? anyNext : (anyNext && (|enableNext));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      maskQ   <= '0;
      enableQ <= '0;
      pendQ   <= 1'b0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
      enableQ <= enableNext;
      pendQ   <= pendNext;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        SEL_STATUS: regRdData = statusQ;
        SEL_MASK:   regRdData = maskQ;
        SEL_ENABLE: regRdData = enableQ;
        default:    regRdData = '0;
      endcase
    end
  end

  assign irqOut = pendQ;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] postVec,
  input  logic [DATA_W-1:0] clearVec,
  input  logic              swReq,
  output logic              irqOut,
  output logic              errOut
);
  reg_strobe_t       strb;
  logic [DATA_W-1:0] postEff;
  logic [DATA_W-1:0] clearEff;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] enableQ;

  irq_status_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .postVec(postVec), .clearVec(clearVec),
    .swReq(swReq), .strb(strb), .postEff(postEff), .clearEff(clearEff),
    .errOut(errOut)
  );

  irq_status_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rst(rst), .strb(strb), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .postEff(postEff),
    .clearEff(clearEff), .regRdData(regRdData), .statusQ(statusQ),
    .maskQ(maskQ), .enableQ(enableQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] postVec,
  input logic [DATA_W-1:0] clearVec,
  input logic              swReq,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] maskQ,
  input logic [DATA_W-1:0] enableQ,
  input logic              irqOut,
  input logic              errOut
);
  localparam logic [DATA_W-1:0] RSVD = ~{{(DATA_W-12){1'b0}}, 12'hFFF};

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irqOut && !errOut && statusQ == '0));

  p_read_empties_r2: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == 2'd0 && postVec == '0 && !swReq) |=> statusQ == '0);

  p_status_write_err_r3: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd0) |=> errOut);

  p_rsvd_err_r7: assert property (@(posedge clk) disable iff (rst)
    (|((postVec | clearVec) & RSVD)) |=> errOut);

  p_rsvd_never_set_r7: assert property (@(posedge clk) disable iff (rst)
    (statusQ & RSVD) == '0);

  p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (|(statusQ & maskQ)));

  p_rise_needs_enable_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> (|enableQ));

  p_mask_stored_r12: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd1) |=> maskQ == $past(regWrData));
endmodule

bind irq_status_unit irq_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .postVec(postVec),
  .clearVec(clearVec), .swReq(swReq), .statusQ(statusQ), .maskQ(maskQ),
  .enableQ(enableQ), .irqOut(irqOut), .errOut(errOut)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, swReq = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0, postVec = '0, clearVec = '0;
  logic [31:0] regRdData;
  logic        irqOut, errOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mSt = '0, mMask = '0, mEn = '0;
  logic        mPend = 0, mErr = 0;

  always #4 clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .postVec(postVec), .clearVec(clearVec), .swReq(swReq),
    .irqOut(irqOut), .errOut(errOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [1:0] a);
    case (a)
      2'd0: return mSt;
      2'd1: return mMask;
      2'd2: return mEn;
      default: return 32'h0;
    endcase
  endfunction

  // one clock: drive, check read, clock, update model, check outputs
  task automatic cyc(input string tag, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [31:0] wd,
                     input logic [31:0] post, input logic [31:0] clr,
                     input logic sw);
    logic [31:0] p, c, ns, nm, ne;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    postVec = post; clearVec = clr; swReq = sw;
    #1;
    check({tag, " rd"}, regRdData, rd ? mRead(a) : 32'h0);
    @(posedge clk);
    p  = (post & 32'hFFF) | (sw ? 32'h200 : 32'h0);
    c  = clr & 32'hFFF;
    ns = ((rd && a == 2'd0) ? 32'h0 : (mSt & ~c)) | p;
    nm = (wr && a == 2'd1) ? wd : mMask;
    ne = (wr && a == 2'd2) ? wd : mEn;
    mErr  = (wr && a == 2'd0) || (((post | clr) & ~32'hFFF) != 0);
    mPend = mPend ? ((ns & nm) != 0) : (((ns & nm) != 0) && ne != 0);
    mSt = ns; mMask = nm; mEn = ne;
    @(negedge clk);
    check({tag, " irq"}, {31'b0, irqOut}, {31'b0, mPend});
    check({tag, " err"}, {31'b0, errOut}, {31'b0, mErr});
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 2'd0, 0, 0, 0, 0);
  endtask
  task automatic rdReg(input string tag, input logic [1:0] a);
    cyc(tag, 0, 1, a, 0, 0, 0, 0);
  endtask
  task automatic wrReg(input string tag, input logic [1:0] a, input logic [31:0] d);
    cyc(tag, 1, 0, a, d, 0, 0, 0);
  endtask
  task automatic post(input string tag, input logic [31:0] v);
    cyc(tag, 0, 0, 2'd0, 0, v, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rdReg("R1 status", 2'd0);
    rdReg("R1 mask", 2'd1);
    rdReg("R1 enable", 2'd2);
    rdReg("R2 unused sel", 2'd3);
    // R4 post without mask, R2 read clears
    post("R4 post txok", 32'h1);
    post("R4 post rxovr", 32'h100);
    rdReg("R2 read returns", 2'd0);
    rdReg("R2 read after clear", 2'd0);
    // R9 masked assert
    wrReg("R12 mask", 2'd1, 32'h0000_0011);
    wrReg("R11 enable", 2'd2, 32'h1);
    post("R9 assert", 32'h1);
    post("R9 second post", 32'h10);
    cyc("R10 clear one", 0, 0, 0, 0, 0, 32'h1, 0);
    cyc("R10 clear last", 0, 0, 0, 0, 0, 32'h10, 0);
    // R5 post and clear same bit
    cyc("R5 post+clear", 0, 0, 0, 0, 32'h4, 32'h4, 0);
    rdReg("R5 bit kept", 2'd0);
    // R6 post during read
    post("R6 pre", 32'h2);
    cyc("R6 post with read", 0, 1, 2'd0, 0, 32'h8, 0, 0);
    rdReg("R6 kept for next", 2'd0);
    // R3 illegal status write
    post("R3 pre", 32'h40);
    wrReg("R3 write status", 2'd0, 32'hFFFF_FFFF);
    rdReg("R3 unchanged", 2'd0);
    // R7 reserved bits
    post("R7 rsvd post", 32'h0010_0001);
    cyc("R7 rsvd clear", 0, 0, 0, 0, 0, 32'h8000_0000, 0);
    rdReg("R7 status", 2'd0);
    // R8 soft request
    cyc("R8 swReq", 0, 0, 0, 0, 0, 0, 1);
    rdReg("R8 bit9", 2'd0);
    // R11 enable gating
    wrReg("R11 disable", 2'd2, 32'h0);
    post("R11 no rise", 32'h1);
    idle("R11 still low");
    wrReg("R11 enable on", 2'd2, 32'h4);
    wrReg("R11 disable held", 2'd2, 32'h0);
    idle("R11 held high");
    rdReg("R10 read drops", 2'd0);
    // R12 mask re-evaluation
    wrReg("R12 enable", 2'd2, 32'h1);
    wrReg("R12 mask off", 2'd1, 32'h0);
    post("R12 unmasked event", 32'h20);
    wrReg("R12 mask on", 2'd1, 32'h20);
    wrReg("R12 mask off drops", 2'd1, 32'h0);
    rdReg("R12 mask read", 2'd1);
    // mixed pseudo-random traffic
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pv, cv;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pv = {20'h0, lfsr[11:0] & lfsr[23:12] & lfsr[19:8]};
      cv = {20'h0, lfsr[15:4] & lfsr[27:16]};
      if (lfsr[31:28] == 4'hF) pv[24] = 1'b1;
      cyc("R9 R10 mixed", lfsr[30:28] == 3'd0, lfsr[27:25] == 3'd1,
          (lfsr[30:28] == 3'd0) ? (lfsr[5] ? 2'd1 : 2'd2) : lfsr[7:6],
          {20'h0, lfsr[20:9]} & (lfsr[4] ? 32'hFFF : 32'h0),
          pv, cv, lfsr[24:22] == 3'd5);
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule